// File: doc/BRIEF.md
# Preloaded Multi-Channel PWM Timer

The block generates edge-aligned pulse-width modulated waveforms on several channels that share one time base. A prescaler divides the clock. A 16-bit up-counter then steps once per prescaler tick and wraps at a programmable reload value. Each channel compares the counter with its own threshold and drives a line whose active level it selects.

All timing values (divide ratio, reload value and compare thresholds) are written through a small register-write port into shadow copies. They reach the working registers only on an update event. An update event is either the counter wrapping or a forced update pulse from software. Because of this, software can reprogram a running waveform without producing a torn period. Writing a new reload value also restarts the counter and the prescaler at once, so a period change begins cleanly. The update pulse output marks every update event, for example to pace the writes of the next duty values.

Top module: `pwm_tmr`

## Requirements
- R1: While rst_ni is low, pwm_o and upd_o are 0. Reset leaves the prescaler and compare registers at 0 and the reload register at 0xFFFF, with the counter at 0.
- R2: With `run_i` high, the counter advances once every P+1 clocks, where P is the active prescaler value. It goes from the active reload value R back to 0, so upd_o pulses every (P+1)*(R+1) clocks.
- R3: A write on wr_addr_i goes to a shadow register only: address 0 is the prescaler, address 1 is the reload value, and addresses 2 to 5 are the compare values of channels 0 to 3. Addresses 6 and 7 are ignored. The waveform does not change until the next update event.
- R4: When the counter wraps, every shadow value is copied into its working register, and upd_o is high for one cycle in the cycle after the last clock of the period. A write landing in that same cycle stays in the shadow until the following update.
- R5: A forced-update pulse loads all shadows and clears the prescaler and the counter. It also pulses upd_o, and it works even while the counter is stopped. It takes priority over every other action.
- R6: A write to the reload address clears the counter and prescaler in the next cycle. It raises no update pulse and loads no working register.
- R7: An enabled channel is active while the counter is below its compare value. A compare value of 0 keeps it inactive all period, and a value of R+1 or more keeps it active all period. pwm_o is registered and reflects the counter value of the previous cycle.
- R8: ch_pol_i bit low makes the active level 1; bit high makes the active level 0.
- R9: A channel whose ch_en_i bit is low drives its inactive level, which equals its ch_pol_i bit.
- R10: With run_i low, the prescaler and counter hold their values, and no wrap update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter run enable |
| force_upd_i | input | 1 | Software forced update pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| ch_en_i | input | 4 | Per-channel output enable |
| ch_pol_i | input | 4 | Per-channel polarity, 1 = active low |
| pwm_o | output | 4 | PWM output lines |
| upd_o | output | 1 | One-cycle update event pulse |

## Verification
The bench targets threshold extremes: a compare value of 0, a value equal to R+1, and a reload of 0. A comparator off by one would show a stray active cycle or a missing one at the period edge. It writes compare values in the middle of a period and expects the waveform to stay unchanged until the wrap. A design without preloading would change the duty at once. It writes the reload value while running and checks that the period restarts with no update pulse, and it forces an update while stopped. A wrong priority or a missing clear would shift every later edge against the reference model. Unused addresses and disabled channels must leave the outputs untouched.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int unsigned ADDR_PSC  = 0;
  localparam int unsigned ADDR_ARR  = 1;
  localparam int unsigned ADDR_CMP0 = 2;
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [CNT_W-1:0]             wr_data_i,
  input  logic                         upd_evt_i,
  output logic                         arr_wr_o,
  output logic [CNT_W-1:0]             psc_o,
  output logic [CNT_W-1:0]             arr_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp_o
);
  logic [CNT_W-1:0] psc_sh, arr_sh;
  logic             psc_wr;

  assign psc_wr   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_PSC));
  assign arr_wr_o = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_ARR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_sh <= '0;
      arr_sh <= '1;
      psc_o  <= '0;
      arr_o  <= '1;
    end else begin
      if (psc_wr)    psc_sh <= wr_data_i;
      if (arr_wr_o)  arr_sh <= wr_data_i;
      // working copies take the pre-write shadow value
      if (upd_evt_i) begin
        psc_o <= psc_sh;
        arr_o <= arr_sh;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    logic [CNT_W-1:0] cmp_sh;
    logic             cmp_wr;
    assign cmp_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMP0 + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_sh   <= '0;
        cmp_o[i] <= '0;
      end else begin
        if (cmp_wr)    cmp_sh   <= wr_data_i;
        if (upd_evt_i) cmp_o[i] <= cmp_sh;
      end
    end
  end

  // R3: working values move only on an update event
  p_preload_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_evt_i |=> ($stable(psc_o) && $stable(arr_o) && $stable(cmp_o)));
endmodule

// File: rtl/pwm_tmr_cnt.sv
module pwm_tmr_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             force_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_evt_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] psc_cnt_q, cnt_q;
  logic             tick, at_top, wrap;

  assign tick      = (psc_cnt_q == psc_i);
  assign at_top    = (cnt_q == arr_i);
  assign wrap      = run_i && tick && at_top && !clr_i && !force_i;
  assign upd_evt_o = force_i || wrap;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      cnt_q     <= '0;
      upd_q_reg <= 1'b0;
    end else begin
      upd_q_reg <= upd_evt_o;
      if (force_i || clr_i) begin
        psc_cnt_q <= '0;
        cnt_q     <= '0;
      end else if (run_i) begin
        if (tick) begin
          psc_cnt_q <= '0;
          cnt_q     <= at_top ? '0 : cnt_q + 1'b1;
        end else begin
          psc_cnt_q <= psc_cnt_q + 1'b1;
        end
      end
    end
  end

  logic upd_q_reg;
  assign upd_o = upd_q_reg;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q <= arr_i) && (psc_cnt_q <= psc_i));
  p_upd_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (cnt_q == '0 && psc_cnt_q == '0));
  p_clr_no_upd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !force_i) |=> (cnt_q == '0 && psc_cnt_q == '0 && !upd_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !force_i && !clr_i) |=> ($stable(cnt_q) && $stable(psc_cnt_q) && !upd_o));
endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  input  logic             pol_i,
  output logic             pwm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 1'b0;
    else         pwm_o <= en_i ? ((cnt_i < cmp_i) ^ pol_i) : pol_i;
  end

  p_dis_inactive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pwm_o == $past(pol_i)));
  p_zero_cmp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0) |=> (pwm_o == $past(pol_i)));
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              force_upd_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_pol_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              upd_o
);
  localparam int unsigned NUM_REGS = 2 + NUM_CH;

  logic [CNT_W-1:0]             psc_act, arr_act, cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
  logic                         arr_wr, upd_evt;

  initial begin
    a_map_fits_r3: assert (NUM_REGS <= (1 << ADDR_W));
  end

  pwm_tmr_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .upd_evt_i (upd_evt),
    .arr_wr_o  (arr_wr),
    .psc_o     (psc_act),
    .arr_o     (arr_act),
    .cmp_o     (cmp_act)
  );

  pwm_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .force_i   (force_upd_i),
    .clr_i     (arr_wr),
    .psc_i     (psc_act),
    .arr_i     (arr_act),
    .cnt_o     (cnt),
    .upd_evt_o (upd_evt),
    .upd_o     (upd_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_tmr_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .cmp_i  (cmp_act[i]),
      .en_i   (ch_en_i[i]),
      .pol_i  (ch_pol_i[i]),
      .pwm_o  (pwm_o[i])
    );
  end

  p_force_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_upd_i |=> upd_o);
endmodule

// File: tb/pwm_tmr_test.sv
module pwm_tmr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 1'b0, force_upd = 1'b0, wen = 1'b0;
  logic [2:0]  waddr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  en = '0, pol = '0;
  logic [3:0]  pwm;
  logic        upd;

  int    n_vec = 0, n_bad = 0;
  string phase_req = "R1";
  logic [4:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_tmr uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .force_upd_i(force_upd),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .ch_en_i(en), .ch_pol_i(pol), .pwm_o(pwm), .upd_o(upd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic [15:0] m_psc_s, m_arr_s, m_psc_a, m_arr_a, m_pc, m_cnt;
  logic [15:0] m_cmp_s[NCH], m_cmp_a[NCH];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_psc_s = '0; m_arr_s = '1; m_psc_a = '0; m_arr_a = '1;
      m_pc = '0; m_cnt = '0;
      for (int i = 0; i < NCH; i++) begin m_cmp_s[i] = '0; m_cmp_a[i] = '0; end
    end else begin
      logic [3:0] npwm;
      logic       nupd, clr, load;
      for (int i = 0; i < NCH; i++)
        npwm[i] = en[i] ? ((m_cnt < m_cmp_a[i]) ^ pol[i]) : pol[i];   // R7 R8 R9
      clr  = wen && (waddr == 3'd1);
      load = 1'b0;
      if (force_upd) begin                                          // R5
        load = 1'b1; m_cnt = '0; m_pc = '0;
      end else if (clr) begin                                       // R6
        m_cnt = '0; m_pc = '0;
      end else if (run) begin                                       // R2 R10
        if (m_pc == m_psc_a) begin
          m_pc = '0;
          if (m_cnt == m_arr_a) begin m_cnt = '0; load = 1'b1; end  // R4
          else m_cnt = m_cnt + 16'd1;
        end else m_pc = m_pc + 16'd1;
      end
      nupd = load;
      if (load) begin
        m_psc_a = m_psc_s; m_arr_a = m_arr_s;
        for (int i = 0; i < NCH; i++) m_cmp_a[i] = m_cmp_s[i];
      end
      if (wen) begin                                                // R3
        case (waddr)
          3'd0: m_psc_s = wdata;
          3'd1: m_arr_s = wdata;
          3'd2, 3'd3, 3'd4, 3'd5: m_cmp_s[waddr - 3'd2] = wdata;
          default: ;
        endcase
      end
      exp_q.push_back({nupd, npwm});
    end
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      e = exp_q.pop_front();
      chk(phase_req, {27'd0, upd, pwm}, {27'd0, e});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wen = 1'b1; waddr = a; wdata = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic pulse_force();
    @(negedge clk); force_upd = 1'b1;
    @(negedge clk); force_upd = 1'b0;
  endtask

  task automatic measure(string req, int exp);
    int n = 0;
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!upd && guard < 5000);
    do begin @(negedge clk); n++; end while (!upd && n < 5000);
    chk(req, n, exp);
    if (exp > 1) begin
      @(negedge clk);
      chk("R4", {31'd0, upd}, 32'd0);  // pulse lasts one cycle
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cnt_upd;
    en = 4'b1111; pol = 4'b1000;
    idle(3);
    chk("R1", {28'd0, pwm}, 32'd0);
    chk("R1", {31'd0, upd}, 32'd0);
    rst_ni = 1'b1;

    phase_req = "R3";
    wr(3'd0, 16'd1); wr(3'd1, 16'd9);
    wr(3'd2, 16'd0); wr(3'd3, 16'd5); wr(3'd4, 16'd10); wr(3'd5, 16'd3);
    idle(4);
    chk("R3", {28'd0, pwm}, 32'h8);   // still reset thresholds: all inactive

    phase_req = "R5";
    pulse_force();
    chk("R5", {31'd0, upd}, 32'd1);   // forced while stopped

    phase_req = "R7";
    run = 1'b1;
    idle(45);
    measure("R2", 20);
    phase_req = "R8";
    pol = 4'b0110;
    idle(25);

    phase_req = "R3";
    idle(7);
    wr(3'd3, 16'd2);
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'h1234);
    idle(50);

    phase_req = "R9";
    en = 4'b0101;
    idle(25);
    pol = 4'b1001;
    idle(25);
    en = 4'b1111;

    phase_req = "R10";
    run = 1'b0;
    cnt_upd = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (upd) cnt_upd++;
    end
    chk("R10", cnt_upd, 0);
    run = 1'b1;
    idle(30);

    phase_req = "R6";
    wr(3'd0, 16'd0);
    idle(5);
    wr(3'd1, 16'd4);
    chk("R6", {31'd0, upd}, 32'd0);
    idle(40);
    measure("R2", 5);

    phase_req = "R4";
    wr(3'd2, 16'd5); wr(3'd5, 16'd1);
    idle(30);
    wr(3'd1, 16'd0);
    pulse_force();
    idle(12);
    measure("R2", 1);

    phase_req = "R5";
    @(negedge clk); force_upd = 1'b1; wen = 1'b1; waddr = 3'd1; wdata = 16'd7;
    @(negedge clk); force_upd = 1'b0; wen = 1'b0;
    chk("R5", {31'd0, upd}, 32'd1);
    idle(40);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule